// File: doc/BRIEF.md
# Timeout Escape Queue for Shared Control Buffer

This block holds single-flit control packets in a small buffer that every message class shares. Normally the packets leave in arrival order on a fast path toward the next hop. Each stored entry carries its own wait counter. When an entry has waited long enough, it may be released into an escape channel dedicated to its message class. A release needs that class's escape credit. It may take any entry, including one that is not the oldest. This removes the dependence between classes that a single shared queue would otherwise create.

After a release, the block records that a packet of that class is sitting in the escape channel. The count is kept per class, so several escaped packets are tracked. While the count is non-zero, fast-path departures of that class are held back, so a later packet cannot overtake an earlier escaped one. The count falls each time the environment reports that an escaped packet of that class has drained.

Top module: `ctrl_escape_buf`

## Requirements
- R1: After reset the buffer is empty, `in_ready` is 1, `fast_valid` is 0, `esc_valid` is all zero and no class is blocked.
- R2: A flit is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly when fewer than DEPTH (2) entries are stored. A flit offered while the buffer is full is dropped and never appears at any output.
- R3: The fast path offers only the oldest stored entry. `fast_flit` shows it, and it departs on an edge where `fast_valid` and `fast_ready` are both 1, so fast departures keep arrival order.
- R4: An entry's wait counter is 0 on the edge that stores it and rises by one on every later edge it stays. The entry becomes eligible for escape once the counter reaches THRESH (64). An entry stored at edge E is first offered in the cycle after edge E+64. The counter saturates at THRESH and never wraps.
- R5: An eligible entry is released only while `esc_credit` is 1 for its own class. On release, `esc_valid` is one-hot at the class index, `esc_flit` carries the flit, and the entry leaves on that edge.
- R6: Release ignores buffer position: a younger eligible entry leaves while an older eligible entry waits for credit.
- R7: When several entries are eligible and have credit, the oldest is released first. At most one entry is released per cycle.
- R8: Each release increments a per-class escape count, and each `esc_drain` pulse for a class with a non-zero count decrements it. While a class's count is non-zero, a head entry of that class is not offered on the fast path.
- R9: A non-zero escape count for one class does not hold back fast-path packets of the other classes.
- R10: The message class is the 2-bit field in flit bits [1:0]. Values 0, 1 and 2 name the three classes, and value 3 is not presented.
- R11: At most one entry leaves per cycle. If the head can depart on the fast path, it does so, and no escape release happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_flit | input | FLIT_W | Incoming flit, class in bits [1:0] |
| in_ready | output | 1 | Buffer has a free entry |
| fast_ready | input | 1 | Next hop fast buffer can take a flit |
| fast_valid | output | 1 | Oldest entry offered on fast path |
| fast_flit | output | FLIT_W | Oldest stored flit |
| esc_credit | input | NCLS | Per-class escape buffer has space |
| esc_valid | output | NCLS | One-hot release into the escape channel of that class |
| esc_flit | output | FLIT_W | Flit being released |
| esc_drain | input | NCLS | Per-class pulse: one escaped packet has left the escape path |

## Verification
Several traffic patterns are used, and each one separates a different kind of faulty design.

- **Single entry, credit present.** The release must appear exactly one cycle after the threshold. This catches off-by-one counter errors.
- **Head without credit, second entry with credit.** The second entry must leave first. A design that keeps strict FIFO order fails here.
- **Long wait before credit arrives.** This shows whether the counter saturates or wraps.
- **Two eligible entries, credit appearing for both.** This shows whether the older entry is released first.
- **Two escapes of one class.** Two drain pulses are then needed before that class's head is offered again. This distinguishes a per-class count from a single flag.
- **Another class queued during the block.** That class must still flow on the fast path.
- **Timeout coinciding with fast-path readiness.** This checks that the fast path has priority.

// File: rtl/ctrl_escape_pkg.sv
package ctrl_escape_pkg;
    // Width of the message-class field at the low end of every flit
    localparam int CLS_W = 2;
    typedef logic [CLS_W-1:0] cls_t;
endpackage

// File: rtl/esc_slot_queue.sv
// Compacting queue: index 0 is always the oldest entry; any index may leave.
module esc_slot_queue
    import ctrl_escape_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int FLIT_W = 16,
    parameter int THRESH = 64,
    parameter int CNT_W  = $clog2(THRESH + 1),
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [FLIT_W-1:0]             push_flit,
    input  logic                          pop_en,
    input  logic [IDX_W-1:0]              pop_idx,
    output logic [DEPTH-1:0]              q_vld,
    output logic [DEPTH-1:0][FLIT_W-1:0]  q_flit,
    output logic [DEPTH-1:0][CNT_W-1:0]   q_cnt,
    output logic [OCC_W-1:0]              q_occ
);
    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][FLIT_W-1:0] flit;
        logic [DEPTH-1:0][CNT_W-1:0]  cnt;
    } qstate_t;

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);

    qstate_t st_d, st_q;
    logic [OCC_W-1:0] occ_q;

    always_comb begin
        occ_q = '0;
        for (int i = 0; i < DEPTH; i++) begin
            occ_q = occ_q + OCC_W'(st_q.vld[i]);
        end
    end

    always_comb begin
        int nxt;
        int slot;
        st_d = st_q;
        // close the gap left by a departing entry
        for (int i = 0; i < DEPTH; i++) begin
            nxt = (i + 1 < DEPTH) ? i + 1 : i;
            if (pop_en && (i >= int'(pop_idx))) begin
                if (i + 1 < DEPTH) begin
                    st_d.vld[i]  = st_q.vld[nxt];
                    st_d.flit[i] = st_q.flit[nxt];
                    st_d.cnt[i]  = st_q.cnt[nxt];
                end else begin
                    st_d.vld[i]  = 1'b0;
                    st_d.cnt[i]  = '0;
                end
            end
        end
        // survivors age by one, saturating at the threshold
        for (int i = 0; i < DEPTH; i++) begin
            if (st_d.vld[i] && (st_d.cnt[i] != CNT_MAX)) begin
                st_d.cnt[i] = st_d.cnt[i] + CNT_W'(1);
            end
        end
        // append the new arrival behind the survivors
        slot = int'(occ_q) - (pop_en ? 1 : 0);
        if (push && (slot < DEPTH)) begin
            st_d.vld[slot]  = 1'b1;
            st_d.flit[slot] = push_flit;
            st_d.cnt[slot]  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_vld  = st_q.vld;
    assign q_flit = st_q.flit;
    assign q_cnt  = st_q.cnt;
    assign q_occ  = occ_q;
endmodule

// File: rtl/esc_pick.sv
// Chooses the single departure of the cycle: fast head first, else oldest eligible escape.
module esc_pick
    import ctrl_escape_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int FLIT_W = 16,
    parameter int NCLS   = 3,
    parameter int THRESH = 64,
    parameter int CNT_W  = $clog2(THRESH + 1),
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]              q_vld,
    input  logic [DEPTH-1:0][FLIT_W-1:0]  q_flit,
    input  logic [DEPTH-1:0][CNT_W-1:0]   q_cnt,
    input  logic [NCLS-1:0]               blocked,
    input  logic [NCLS-1:0]               esc_credit,
    input  logic                          fast_ready,
    output logic                          fast_valid,
    output logic [NCLS-1:0]               esc_valid,
    output logic [FLIT_W-1:0]             esc_flit,
    output logic                          pop_en,
    output logic [IDX_W-1:0]              pop_idx
);
    localparam logic [NCLS-1:0]  ONE_HOT0 = NCLS'(1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(THRESH);

    function automatic logic [NCLS-1:0] cls_mask(input logic [FLIT_W-1:0] f);
        return ONE_HOT0 << f[CLS_W-1:0];
    endfunction

    logic             fast_fire;
    logic             found;
    logic [IDX_W-1:0] sel;

    always_comb begin
        fast_valid = q_vld[0] && ((cls_mask(q_flit[0]) & blocked) == '0);
        fast_fire  = fast_valid && fast_ready;

        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && q_vld[i] && (q_cnt[i] == CNT_MAX) &&
                ((cls_mask(q_flit[i]) & esc_credit) != '0)) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end

        esc_flit  = q_flit[sel];
        esc_valid = '0;
        pop_en    = 1'b0;
        pop_idx   = '0;
        if (fast_fire) begin
            pop_en  = 1'b1;
        end else if (found) begin
            esc_valid = cls_mask(q_flit[sel]);
            pop_en    = 1'b1;
            pop_idx   = sel;
        end
    end
endmodule

// File: rtl/esc_class_track.sv
// Per-class count of packets parked in the escape path.
module esc_class_track #(
    parameter int NCLS  = 3,
    parameter int OCC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] release_cls,
    input  logic [NCLS-1:0] drain_cls,
    output logic [NCLS-1:0] blocked
);
    localparam logic [OCC_W-1:0] OCC_MAX = '1;

    typedef struct packed {
        logic [NCLS-1:0][OCC_W-1:0] occ;
    } track_t;

    track_t tr_d, tr_q;

    always_comb begin
        logic dn;
        tr_d = tr_q;
        for (int c = 0; c < NCLS; c++) begin
            dn = drain_cls[c] && (tr_q.occ[c] != '0);
            if (release_cls[c] && !dn && (tr_q.occ[c] != OCC_MAX)) begin
                tr_d.occ[c] = tr_q.occ[c] + OCC_W'(1);
            end else if (dn && !release_cls[c]) begin
                tr_d.occ[c] = tr_q.occ[c] - OCC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    always_comb begin
        for (int c = 0; c < NCLS; c++) begin
            blocked[c] = (tr_q.occ[c] != '0);
        end
    end
endmodule

// File: rtl/ctrl_escape_buf.sv
module ctrl_escape_buf
    import ctrl_escape_pkg::*;
#(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 2,
    parameter int NCLS   = 3,
    parameter int THRESH = 64,
    parameter int OCC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              in_ready,
    input  logic              fast_ready,
    output logic              fast_valid,
    output logic [FLIT_W-1:0] fast_flit,
    input  logic [NCLS-1:0]   esc_credit,
    output logic [NCLS-1:0]   esc_valid,
    output logic [FLIT_W-1:0] esc_flit,
    input  logic [NCLS-1:0]   esc_drain
);
    localparam int CNT_W = $clog2(THRESH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int QOC_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]             q_vld;
    logic [DEPTH-1:0][FLIT_W-1:0] q_flit;
    logic [DEPTH-1:0][CNT_W-1:0]  q_cnt;
    logic [QOC_W-1:0]             q_occ;
    logic [NCLS-1:0]              blocked;
    logic                         pop_en;
    logic [IDX_W-1:0]             pop_idx;
    logic                         push;

    assign in_ready  = (int'(q_occ) < DEPTH);
    assign push      = in_valid && in_ready;
    assign fast_flit = q_flit[0];

    esc_slot_queue #(
        .DEPTH(DEPTH), .FLIT_W(FLIT_W), .THRESH(THRESH),
        .CNT_W(CNT_W), .IDX_W(IDX_W), .OCC_W(QOC_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_flit(in_flit),
        .pop_en(pop_en), .pop_idx(pop_idx),
        .q_vld(q_vld), .q_flit(q_flit), .q_cnt(q_cnt), .q_occ(q_occ)
    );

    esc_pick #(
        .DEPTH(DEPTH), .FLIT_W(FLIT_W), .NCLS(NCLS),
        .THRESH(THRESH), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_pick (
        .q_vld(q_vld), .q_flit(q_flit), .q_cnt(q_cnt),
        .blocked(blocked), .esc_credit(esc_credit), .fast_ready(fast_ready),
        .fast_valid(fast_valid), .esc_valid(esc_valid), .esc_flit(esc_flit),
        .pop_en(pop_en), .pop_idx(pop_idx)
    );

    esc_class_track #(
        .NCLS(NCLS), .OCC_W(OCC_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .release_cls(esc_valid), .drain_cls(esc_drain),
        .blocked(blocked)
    );
endmodule

// File: rtl/ctrl_escape_buf_chk.sv
module ctrl_escape_buf_chk #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 2,
    parameter int NCLS   = 3,
    parameter int THRESH = 64,
    parameter int CNT_W  = $clog2(THRESH + 1)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_ready,
    input logic                          fast_valid,
    input logic                          fast_ready,
    input logic [FLIT_W-1:0]             fast_flit,
    input logic [NCLS-1:0]               esc_valid,
    input logic [NCLS-1:0]               esc_credit,
    input logic [NCLS-1:0]               esc_drain,
    input logic [NCLS-1:0]               blocked,
    input logic [DEPTH-1:0]              q_vld,
    input logic [DEPTH-1:0][CNT_W-1:0]   q_cnt
);
    localparam logic [NCLS-1:0] ONE_HOT0 = NCLS'(1);

    logic cnt_over;
    always_comb begin
        cnt_over = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_vld[i] && (int'(q_cnt[i]) > THRESH)) cnt_over = 1'b1;
        end
    end

    assert_esc_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(esc_valid));

    assert_esc_needs_credit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_valid & ~esc_credit) == '0);

    assert_fast_not_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fast_valid |-> ((ONE_HOT0 << fast_flit[1:0]) & blocked) == '0);

    assert_release_sets_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((esc_valid != '0) && ((esc_valid & esc_drain) == '0))
            |=> ((blocked & $past(esc_valid)) == $past(esc_valid)));

    assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_over);

    assert_full_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(q_vld) == DEPTH) |-> !in_ready);

    assert_one_departure_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fast_valid && fast_ready && (esc_valid != '0)));
endmodule

bind ctrl_escape_buf ctrl_escape_buf_chk #(
    .FLIT_W(FLIT_W), .DEPTH(DEPTH), .NCLS(NCLS), .THRESH(THRESH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
    .fast_valid(fast_valid), .fast_ready(fast_ready), .fast_flit(fast_flit),
    .esc_valid(esc_valid), .esc_credit(esc_credit), .esc_drain(esc_drain),
    .blocked(blocked), .q_vld(q_vld), .q_cnt(q_cnt)
);

// File: tb/sim_ctrl_escape_buf.sv
module sim_ctrl_escape_buf;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_flit;
    logic        in_ready;
    logic        fast_ready;
    logic        fast_valid;
    logic [15:0] fast_flit;
    logic [2:0]  esc_credit;
    logic [2:0]  esc_valid;
    logic [15:0] esc_flit;
    logic [2:0]  esc_drain;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ctrl_escape_buf u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .fast_ready(fast_ready), .fast_valid(fast_valid), .fast_flit(fast_flit),
        .esc_credit(esc_credit), .esc_valid(esc_valid), .esc_flit(esc_flit),
        .esc_drain(esc_drain)
    );

    function automatic logic [15:0] mk(input logic [7:0] tag, input logic [1:0] c);
        return {6'b0, tag, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_flit    = '0;
        fast_ready = 1'b0;
        esc_credit = '0;
        esc_drain  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [15:0] f);
        in_valid = 1'b1;
        in_flit  = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain_pulse(input logic [2:0] m);
        esc_drain = m;
        @(negedge clk);
        esc_drain = '0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        chk("R1 fast_valid", 32'(fast_valid), 32'd0);
        chk("R1 esc_valid", 32'(esc_valid), 32'd0);
        fast_ready = 1'b1;
        push(mk(8'h11, 2'd0));
        chk("R1 no class blocked", 32'(fast_valid), 32'd1);
    endtask

    task automatic t_fifo();
        do_reset();
        push(mk(8'h21, 2'd0));
        push(mk(8'h22, 2'd1));
        chk("R2 full not ready", 32'(in_ready), 32'd0);
        chk("R3 head valid", 32'(fast_valid), 32'd1);
        chk("R3 head flit", 32'(fast_flit), 32'(mk(8'h21, 2'd0)));
        push(mk(8'h23, 2'd2));
        fast_ready = 1'b1;
        @(negedge clk);
        chk("R3 second in order", 32'(fast_flit), 32'(mk(8'h22, 2'd1)));
        @(negedge clk);
        chk("R2 dropped flit absent", 32'(fast_valid), 32'd0);
    endtask

    task automatic t_timeout();
        do_reset();
        esc_credit = 3'b111;
        push(mk(8'h31, 2'd0));
        repeat (63) @(negedge clk);
        chk("R4 not eligible at 63", 32'(esc_valid), 32'd0);
        @(negedge clk);
        chk("R4 eligible at 64", 32'(esc_valid), 32'b001);
        chk("R5 escape flit", 32'(esc_flit), 32'(mk(8'h31, 2'd0)));
        @(negedge clk);
        chk("R5 entry left", 32'(fast_valid), 32'd0);
    endtask

    task automatic t_saturate();
        do_reset();
        push(mk(8'h41, 2'd2));
        repeat (200) @(negedge clk);
        chk("R5 no credit no release", 32'(esc_valid), 32'd0);
        esc_credit = 3'b011;
        #1;
        chk("R5 wrong class credit", 32'(esc_valid), 32'd0);
        esc_credit = 3'b100;
        #1;
        chk("R4 saturated counter still eligible", 32'(esc_valid), 32'b100);
        chk("R10 class from bits 1:0", 32'(esc_flit), 32'(mk(8'h41, 2'd2)));
    endtask

    task automatic t_any_pos();
        do_reset();
        esc_credit = 3'b010;
        push(mk(8'h51, 2'd0));
        push(mk(8'h52, 2'd1));
        repeat (63) @(negedge clk);
        chk("R6 head eligible lacks credit", 32'(esc_valid), 32'd0);
        @(negedge clk);
        chk("R6 younger released", 32'(esc_valid), 32'b010);
        chk("R6 younger flit", 32'(esc_flit), 32'(mk(8'h52, 2'd1)));
        @(negedge clk);
        chk("R6 older remains", 32'(fast_flit), 32'(mk(8'h51, 2'd0)));
        chk("R6 slot freed", 32'(in_ready), 32'd1);
    endtask

    task automatic t_oldest();
        do_reset();
        push(mk(8'h61, 2'd2));
        push(mk(8'h62, 2'd1));
        repeat (70) @(negedge clk);
        esc_credit = 3'b110;
        #1;
        chk("R7 oldest first", 32'(esc_valid), 32'b100);
        chk("R7 oldest flit", 32'(esc_flit), 32'(mk(8'h61, 2'd2)));
        @(negedge clk);
        chk("R7 next released", 32'(esc_valid), 32'b010);
        @(negedge clk);
        chk("R7 both gone", 32'(esc_valid), 32'd0);
    endtask

    task automatic t_block();
        do_reset();
        esc_credit = 3'b001;
        push(mk(8'h71, 2'd0));
        repeat (65) @(negedge clk);
        esc_credit = '0;
        push(mk(8'h72, 2'd1));
        chk("R9 other class flows", 32'(fast_valid), 32'd1);
        chk("R9 other class flit", 32'(fast_flit), 32'(mk(8'h72, 2'd1)));
        fast_ready = 1'b1;
        @(negedge clk);
        push(mk(8'h73, 2'd0));
        chk("R8 same class held", 32'(fast_valid), 32'd0);
        drain_pulse(3'b001);
        chk("R8 released after drain", 32'(fast_valid), 32'd1);
    endtask

    task automatic t_block2();
        do_reset();
        esc_credit = 3'b001;
        push(mk(8'h81, 2'd0));
        push(mk(8'h82, 2'd0));
        repeat (70) @(negedge clk);
        esc_credit = '0;
        fast_ready = 1'b1;
        push(mk(8'h83, 2'd0));
        chk("R8 held with two escaped", 32'(fast_valid), 32'd0);
        drain_pulse(3'b001);
        chk("R8 held after one drain", 32'(fast_valid), 32'd0);
        drain_pulse(3'b001);
        chk("R8 free after second drain", 32'(fast_valid), 32'd1);
    endtask

    task automatic t_fast_pri();
        do_reset();
        push(mk(8'h91, 2'd0));
        repeat (70) @(negedge clk);
        esc_credit = 3'b001;
        fast_ready = 1'b1;
        #1;
        chk("R11 fast offered", 32'(fast_valid), 32'd1);
        chk("R11 no escape same cycle", 32'(esc_valid), 32'd0);
        @(negedge clk);
        push(mk(8'h92, 2'd0));
        chk("R11 fast departure sets no block", 32'(fast_valid), 32'd1);
    endtask

    initial begin
        t_reset();
        t_fifo();
        t_timeout();
        t_saturate();
        t_any_pos();
        t_oldest();
        t_block();
        t_block2();
        t_fast_pri();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule